// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Idle-Gap Control

This block turns bytes held in an external first-word-fall-through queue into asynchronous serial frames on one output line. Bit timing comes from a baud tick supplied by an external divider at sixteen times the bit rate, so every decision in the block is taken on a tick. Frame shape is set by configuration inputs: character length, parity, stop length and line polarity. A minimum quiet interval can be imposed after every frame. A break request makes the block send a run of all-low character periods once the queued data has gone out.

Three one-cycle status pulses report progress. The first marks the end of the last queued character. The second marks the end of a break. The third marks the point where the required quiet interval has elapsed. The state machine has six states: IDLE (line high), START, DATA, PARITY, STOP and BREAK. Its transitions are: IDLE to START (launch, a byte is popped), IDLE to BREAK (break launch), START to DATA at the end of the start slot, DATA to PARITY or DATA to STOP after the last data bit, PARITY to STOP, and STOP or BREAK to START, BREAK or IDLE at frame end (a direct relaunch is taken only when the gap is zero).

Top module: `uart_tx_break`

## Requirements
- R1: After reset, and whenever the machine rests in IDLE, the line sits at logic 1 before inversion. The status pulses and the pop stay low while nothing is sent.
- R2: A frame is a start slot at 0 for 16 ticks, followed by the data bits from bit 0 upward, 16 ticks each. The data length code 0, 1, 2, 3 selects 5, 6, 7 or 8 bits.
- R3: With parity enabled, one 16-tick parity slot follows the data. Its value is the XOR of the sent data bits, inverted when odd parity is selected.
- R4: The stop slot is at 1 and lasts 16 ticks for code 0, 24 for code 1, and 32 for codes 2 and 3.
- R5: When the invert input is 1, the output line is the complement of the frame and idle levels.
- R6: Each frame pops the queue exactly once, only on a baud tick and only while the queue is not empty.
- R7: tx_done pulses once when a stop slot ends with the queue empty, in the cycle after that tick.
- R8: A break starts only once the queue is empty, the break request is high and the required gap has passed. It holds the line at 0 for N character periods, each (1 + data bits + parity) x 16 ticks plus the stop length. A count of 0 acts as 1. Only one break is sent per assertion of the request.
- R9: brk_done pulses once, in the cycle after the tick that ends the last break character.
- R10: After a frame or break, the next launch waits exactly idle_bits x 16 ticks of high line. With 0, a waiting byte starts on the very tick that ends the stop slot.
- R11: idle_done pulses once per frame or break end, on the tick where the quiet count reaches idle_bits x 16. With 0, it pulses on the ending tick itself.
- R12: The machine state changes only on baud-tick cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_empty | input | 1 | Queue holds no byte |
| fifo_data | input | 8 | Byte at the head of the queue |
| fifo_pop | output | 1 | Removes the head byte |
| cfg_data_len | input | 2 | Data length code (5 + code bits) |
| cfg_parity_en | input | 1 | Append parity slot |
| cfg_parity_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop_len | input | 2 | Stop length code |
| cfg_invert | input | 1 | Complement the output line |
| cfg_idle_bits | input | 8 | Minimum quiet gap in bit times |
| brk_req | input | 1 | Request a break after pending data |
| brk_count | input | 8 | Number of break characters |
| txd | output | 1 | Serial output line |
| tx_done | output | 1 | Queue drained pulse |
| brk_done | output | 1 | Break finished pulse |
| idle_done | output | 1 | Quiet interval reached pulse |

## Verification
The bench records the line once per baud tick. It sweeps every combination of data length, parity mode (none, even, odd) and stop code over two-byte bursts, with byte values that vary from case to case. This separates errors in bit order, slot length and parity sense. Separate runs with non-zero gaps, inverted polarity and breaks cover three things: the exact quiet count between frames, the break length under different frame shapes, and the zero-count rule for breaks. In each run the tick index of every status pulse is compared with the index derived from the expected waveform, so a pulse issued one tick early or late is caught.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BREAK
    } tx_state_t;

endpackage

// File: rtl/uart_tx_slot_timer.sv
module uart_tx_slot_timer #(
    parameter int OS    = 16,
    parameter int CNT_W = $clog2(2*OS+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             slot_end
);
    logic [CNT_W-1:0] cnt_q;

    assign slot_end = tick && !hold && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == limit - CNT_W'(1)) cnt_q <= '0;
            else                            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // slot counter never exceeds the longest stop slot
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(2*OS));

endmodule

// File: rtl/uart_tx_gap.sv
module uart_tx_gap #(
    parameter int OS     = 16,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              arm,
    input  logic [IDLE_W-1:0] idle_bits,
    output logic              go_ok,
    output logic              zero_gap,
    output logic              idle_done
);
    localparam int TGT_W = IDLE_W + $clog2(OS) + 1;

    logic [TGT_W-1:0] target;
    logic [TGT_W-1:0] cnt_q;
    logic [TGT_W-1:0] cnt_inc;
    logic             met_q;
    logic             reach;
    logic             done_q;

    assign target    = TGT_W'(idle_bits) * TGT_W'(OS);
    assign zero_gap  = (idle_bits == '0);
    assign cnt_inc   = cnt_q + TGT_W'(1);
    assign reach     = (cnt_inc >= target);
    assign go_ok     = met_q || (tick && !arm && reach);
    assign idle_done = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            met_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (arm) begin
            cnt_q  <= '0;
            met_q  <= zero_gap;
            done_q <= zero_gap;
        end else if (tick && !met_q) begin
            cnt_q  <= cnt_inc;
            met_q  <= reach;
            done_q <= reach;
        end else begin
            done_q <= 1'b0;
        end
    end

    // one pulse per quiet period
    assert_idle_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_done |=> !idle_done);

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int OS     = 16,
    parameter int DATA_W = 8,
    parameter int BRK_W  = 8,
    parameter int CNT_W  = $clog2(2*OS+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              brk_req,
    input  logic [BRK_W-1:0]  brk_count,
    input  logic              slot_end,
    input  logic              go_ok,
    input  logic              zero_gap,
    output logic              fifo_pop,
    output logic [CNT_W-1:0]  slot_limit,
    output logic              timer_hold,
    output logic              line_raw,
    output logic              arm,
    output logic              tx_done,
    output logic              brk_done,
    output logic              in_idle
);
    localparam int IDX_W = 4;

    tx_state_t         state_q, st_d;
    logic [IDX_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic [BRK_W-1:0]  brk_left_q;
    logic              brk_stop_q;
    logic              brk_armed_q;
    logic              tx_done_q;
    logic              brk_done_q;

    logic [IDX_W-1:0]  n_data;
    logic [IDX_W-1:0]  n_full;
    logic [CNT_W-1:0]  stop_ticks;
    logic [DATA_W-1:0] mask;
    logic              load_par;
    logic              frame_end;
    logic              brk_end;
    logic              launch_win;
    logic              want_data;
    logic              want_brk;

    always_comb begin
        n_data = IDX_W'(5) + IDX_W'(cfg_len);
        n_full = IDX_W'(1) + n_data + IDX_W'(cfg_par_en);
        unique case (cfg_stop)
            2'd0:    stop_ticks = CNT_W'(OS);
            2'd1:    stop_ticks = CNT_W'(OS + OS/2);
            default: stop_ticks = CNT_W'(2*OS);
        endcase
        mask     = DATA_W'((32'd1 << n_data) - 32'd1);
        load_par = (^(fifo_data & mask)) ^ cfg_par_odd;
    end

    always_comb begin
        frame_end  = (state_q == S_STOP) && slot_end;
        brk_end    = (state_q == S_BREAK) && brk_stop_q && slot_end &&
                     (brk_left_q <= BRK_W'(1));
        launch_win = (state_q == S_IDLE) ? (baud_tick && go_ok)
                                         : ((frame_end || brk_end) && zero_gap);
        want_data  = launch_win && !fifo_empty;
        want_brk   = launch_win && fifo_empty && brk_req && brk_armed_q;
    end

    // next-state logic
    always_comb begin
        st_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (want_data)     st_d = S_START;
                else if (want_brk) st_d = S_BREAK;
            end
            S_START: if (slot_end) st_d = S_DATA;
            S_DATA: begin
                if (slot_end && (bit_q == n_data - IDX_W'(1)))
                    st_d = cfg_par_en ? S_PAR : S_STOP;
            end
            S_PAR: if (slot_end) st_d = S_STOP;
            S_STOP, S_BREAK: begin
                if (frame_end || brk_end) begin
                    if (want_data)     st_d = S_START;
                    else if (want_brk) st_d = S_BREAK;
                    else               st_d = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            bit_q       <= '0;
            sh_q        <= '0;
            par_q       <= 1'b0;
            brk_left_q  <= '0;
            brk_stop_q  <= 1'b0;
            brk_armed_q <= 1'b1;
            tx_done_q   <= 1'b0;
            brk_done_q  <= 1'b0;
        end else begin
            state_q    <= st_d;
            tx_done_q  <= frame_end && fifo_empty;
            brk_done_q <= brk_end;
            if (!brk_req)      brk_armed_q <= 1'b1;
            else if (want_brk) brk_armed_q <= 1'b0;

            if (want_data) begin
                sh_q  <= fifo_data;
                par_q <= load_par;
                bit_q <= '0;
            end else if (want_brk) begin
                bit_q      <= '0;
                brk_stop_q <= 1'b0;
                brk_left_q <= (brk_count == '0) ? BRK_W'(1) : brk_count;
            end else if (slot_end) begin
                if (state_q == S_DATA) begin
                    sh_q  <= sh_q >> 1;
                    bit_q <= (bit_q == n_data - IDX_W'(1)) ? '0 : bit_q + IDX_W'(1);
                end else if (state_q == S_BREAK) begin
                    if (!brk_stop_q) begin
                        if (bit_q == n_full - IDX_W'(1)) begin
                            brk_stop_q <= 1'b1;
                            bit_q      <= '0;
                        end else begin
                            bit_q <= bit_q + IDX_W'(1);
                        end
                    end else if (brk_left_q > BRK_W'(1)) begin
                        brk_left_q <= brk_left_q - BRK_W'(1);
                        brk_stop_q <= 1'b0;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        fifo_pop   = want_data;
        arm        = frame_end || brk_end;
        timer_hold = (state_q == S_IDLE);
        in_idle    = (state_q == S_IDLE);
        tx_done    = tx_done_q;
        brk_done   = brk_done_q;
        slot_limit = ((state_q == S_STOP) || ((state_q == S_BREAK) && brk_stop_q))
                     ? stop_ticks : CNT_W'(OS);
        unique case (state_q)
            S_IDLE:  line_raw = 1'b1;
            S_START: line_raw = 1'b0;
            S_DATA:  line_raw = sh_q[0];
            S_PAR:   line_raw = par_q;
            S_STOP:  line_raw = 1'b1;
            S_BREAK: line_raw = 1'b0;
            default: line_raw = 1'b1;
        endcase
    end

    assert_state_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(state_q));

    assert_pop_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!fifo_empty && baud_tick));

    assert_pop_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (state_q == S_START));

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic txd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= raw ^ invert;
    end
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break #(
    parameter int OS     = 16,
    parameter int DATA_W = 8,
    parameter int BRK_W  = 8,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic [1:0]        cfg_data_len,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic [1:0]        cfg_stop_len,
    input  logic              cfg_invert,
    input  logic [IDLE_W-1:0] cfg_idle_bits,
    input  logic              brk_req,
    input  logic [BRK_W-1:0]  brk_count,
    output logic              txd,
    output logic              tx_done,
    output logic              brk_done,
    output logic              idle_done
);
    localparam int CNT_W = $clog2(2*OS+1);

    logic             slot_end;
    logic             go_ok;
    logic             zero_gap;
    logic [CNT_W-1:0] slot_limit;
    logic             timer_hold;
    logic             line_raw;
    logic             arm;
    logic             in_idle;

    uart_tx_slot_timer #(.OS(OS), .CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .hold(timer_hold),
        .limit(slot_limit), .slot_end(slot_end)
    );

    uart_tx_gap #(.OS(OS), .IDLE_W(IDLE_W)) i_gap (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .arm(arm),
        .idle_bits(cfg_idle_bits), .go_ok(go_ok), .zero_gap(zero_gap),
        .idle_done(idle_done)
    );

    uart_tx_fsm #(.OS(OS), .DATA_W(DATA_W), .BRK_W(BRK_W), .CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .cfg_len(cfg_data_len), .cfg_par_en(cfg_parity_en),
        .cfg_par_odd(cfg_parity_odd), .cfg_stop(cfg_stop_len),
        .brk_req(brk_req), .brk_count(brk_count),
        .slot_end(slot_end), .go_ok(go_ok), .zero_gap(zero_gap),
        .fifo_pop(fifo_pop), .slot_limit(slot_limit), .timer_hold(timer_hold),
        .line_raw(line_raw), .arm(arm), .tx_done(tx_done), .brk_done(brk_done),
        .in_idle(in_idle)
    );

    uart_tx_line i_line (
        .clk(clk), .rst_n(rst_n), .raw(line_raw), .invert(cfg_invert), .txd(txd)
    );

    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |=> (txd == !$past(cfg_invert)));

    assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && brk_done));

endmodule

// File: tb/test_uart_tx_break.sv
module test_uart_tx_break;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       fifo_pop;
    logic [1:0] cfg_data_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic [1:0] cfg_stop_len = 2'd0;
    logic       cfg_invert = 1'b0;
    logic [7:0] cfg_idle_bits = 8'd0;
    logic       brk_req = 1'b0;
    logic [7:0] brk_count = 8'd0;
    logic       txd;
    logic       tx_done;
    logic       brk_done;
    logic       idle_done;

    always #10 clk = ~clk;

    uart_tx_break i_uart_tx_break (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_stop_len(cfg_stop_len),
        .cfg_invert(cfg_invert), .cfg_idle_bits(cfg_idle_bits),
        .brk_req(brk_req), .brk_count(brk_count),
        .txd(txd), .tx_done(tx_done), .brk_done(brk_done), .idle_done(idle_done)
    );

    // queue model
    logic [7:0] fmem [0:63];
    int wr_n = 0;
    int rd_n = 0;
    assign fifo_empty = (wr_n == rd_n);
    assign fifo_data  = fmem[rd_n[5:0]];
    initial forever begin
        @(posedge clk);
        if (fifo_pop) rd_n <= rd_n + 1;
    end

    // baud tick: one cycle in three
    int ph = 0;
    initial forever begin
        @(posedge clk);
        baud_tick <= (ph == 2);
        ph <= (ph == 2) ? 0 : ph + 1;
    end

    // recorder: one sample per tick, pulses tagged with the latest tick index
    bit rec  [0:4095];
    bit ebit [0:4095];
    int e_n = 0;
    int rec_n = 0;
    int n_txd = 0, n_brk = 0, n_idle = 0, n_pop = 0;
    int at_txd = -1, at_brk = -1, at_idle = -1;
    initial forever begin
        @(negedge clk);
        if (baud_tick && rec_n < 4096) begin
            rec[rec_n] = txd ^ cfg_invert;
            rec_n++;
        end
        if (tx_done)   begin n_txd++;  at_txd  = rec_n - 1; end
        if (brk_done)  begin n_brk++;  at_brk  = rec_n - 1; end
        if (idle_done) begin n_idle++; at_idle = rec_n - 1; end
        if (fifo_pop)  n_pop++;
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic add(input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            if (e_n < 4096) ebit[e_n] = v;
            e_n++;
        end
    endtask

    task automatic run_case(input int len, input int pmode, input int stp, input bit inv,
                            input int gap, input int nb, input bit brk, input int bn,
                            input int seed, input string tag);
        int dl, pen, stopt, last_stop, brk_idx, end_idx, lim, bad_at;
        logic [7:0] byt [0:7];
        dl    = 5 + len;
        pen   = (pmode != 0) ? 1 : 0;
        stopt = (stp == 0) ? 16 : (stp == 1) ? 24 : 32;
        @(negedge clk); #1;
        cfg_data_len   = len[1:0];
        cfg_parity_en  = (pmode != 0);
        cfg_parity_odd = (pmode == 2);
        cfg_stop_len   = stp[1:0];
        cfg_invert     = inv;
        cfg_idle_bits  = gap[7:0];
        repeat (60) @(negedge clk);
        // R1 R5: idle level before any traffic
        chk(txd == !inv, {tag, " R1 R5 idle level"}, txd, !inv);
        #1;
        rec_n = 0; n_txd = 0; n_brk = 0; n_idle = 0; n_pop = 0;
        at_txd = -1; at_brk = -1; at_idle = -1;
        for (int b = 0; b < nb; b++) begin
            byt[b] = 8'((seed * 73 + b * 29 + 5) & 255);
            fmem[wr_n[5:0]] = byt[b];
            wr_n++;
        end
        brk_req   = brk;
        brk_count = bn[7:0];
        // expected per-tick waveform
        e_n = 0;
        add(1'b1, 1);
        last_stop = -1;
        for (int b = 0; b < nb; b++) begin
            bit p;
            if (b > 0) add(1'b1, gap * 16);
            add(1'b0, 16);
            p = (pmode == 2);
            for (int i = 0; i < dl; i++) begin
                add(byt[b][i], 16);
                p = p ^ byt[b][i];
            end
            if (pen != 0) add(p, 16);
            add(1'b1, stopt);
            last_stop = e_n - 1;
        end
        brk_idx = -1;
        if (brk) begin
            if (nb > 0) add(1'b1, gap * 16);
            add(1'b0, ((bn == 0) ? 1 : bn) * (16 * (1 + dl + pen) + stopt));
            brk_idx = e_n - 1;
        end
        end_idx = brk ? brk_idx : last_stop;
        lim = e_n + gap * 16 + 30;
        while (rec_n < lim) @(negedge clk);
        #1;
        brk_req = 1'b0;
        // R2 R3 R4 R8 R10 R12: tick-by-tick line shape
        bad_at = -1;
        for (int i = 0; i < lim; i++) begin
            bit ev;
            ev = (i < e_n) ? ebit[i] : 1'b1;
            if (bad_at < 0 && rec[i] != ev) bad_at = i;
        end
        chk(bad_at < 0, {tag, " R2 R3 R4 R8 R10 R12 waveform, first bad tick"}, bad_at, -1);
        // R6: one pop per frame
        chk(n_pop == nb, {tag, " R6 pops"}, n_pop, nb);
        // R7: queue drained pulse
        chk(n_txd == ((nb > 0) ? 1 : 0), {tag, " R7 tx_done count"}, n_txd, (nb > 0) ? 1 : 0);
        if (nb > 0) chk(at_txd == last_stop, {tag, " R7 tx_done tick"}, at_txd, last_stop);
        // R9: break finished pulse
        chk(n_brk == (brk ? 1 : 0), {tag, " R9 brk_done count"}, n_brk, brk ? 1 : 0);
        if (brk) chk(at_brk == brk_idx, {tag, " R9 brk_done tick"}, at_brk, brk_idx);
        // R11: quiet interval pulse
        chk(n_idle == nb + (brk ? 1 : 0), {tag, " R11 idle_done count"}, n_idle, nb + (brk ? 1 : 0));
        chk(at_idle == end_idx + gap * 16, {tag, " R11 idle_done tick"}, at_idle, end_idx + gap * 16);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(!fifo_pop && !tx_done && !brk_done && !idle_done, "R1 reset outputs",
            {fifo_pop, tx_done, brk_done, idle_done}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(txd == 1'b1 && !fifo_pop, "R1 idle after reset", txd, 1);

        // sweep of frame shapes, back to back with no gap
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 3; pm++)
                for (int st = 0; st < 3; st++)
                    run_case(len, pm, st, 1'b0, 0, 2, 1'b0, 0, len * 9 + pm * 3 + st, "sweep");

        run_case(3, 1, 3, 1'b0, 1, 3, 1'b0, 0, 40, "gap1 R10");
        run_case(1, 2, 1, 1'b1, 3, 2, 1'b0, 0, 41, "gap3 invert R5");
        run_case(3, 0, 0, 1'b0, 0, 2, 1'b1, 2, 42, "break after data R8");
        run_case(2, 1, 2, 1'b0, 2, 0, 1'b1, 0, 43, "break alone count0 R8");
        run_case(0, 2, 1, 1'b1, 1, 1, 1'b1, 3, 44, "break gap invert R8");
        run_case(3, 2, 0, 1'b0, 2, 3, 1'b0, 0, 45, "gap2 R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule